// File: doc/BRIEF.md
# Wake-up Key Power-Enable Controller

This block sits in an always-on domain clocked at 32.768 kHz. It watches one active-high wake-up key and drives the enable for a separately switched power domain. The raw key is synchronised and debounced. One counter then measures how long the key has been held without a break. A hold of one second (32768 cycles) turns the domain on. A hold of ten seconds (327680 cycles) turns it off whatever state it is in. This second threshold lets the domain be shut down even when its firmware has hung.

Firmware can also switch the domain off through a request input. A status flag reports that the last power-off was forced by the long hold. After a forced power-off, the key has no effect until it is released. A single long hold therefore cannot bring the domain back on. All cycle counts are parameters, so a test can run the block with shortened times.

Top module: `wkey_pwr_ctrl`

## Requirements
- R1: While the active-low reset `rst_n` is low, `pwr_en` and `forced_off` are 0. They go to 0 as soon as reset is asserted, without waiting for a clock edge.
- R2: The key is active high. A level on `key_raw` is accepted only after it passes SYNC_STAGES flops and then holds for DEBOUNCE_CYC consecutive cycles. A pulse shorter than DEBOUNCE_CYC cycles has no effect on `pwr_en`.
- R3: An unbroken press raises `pwr_en` exactly SYNC_STAGES + DEBOUNCE_CYC + HOLD_ON_CYC + 1 clock edges after `key_raw` rises.
- R4: Releasing the key clears the hold count. A press shorter than the on-threshold, followed by a release and a new press, is timed from the new press only.
- R5: An unbroken press lasting SYNC_STAGES + DEBOUNCE_CYC + HOLD_OFF_CYC + 1 edges drives `pwr_en` to 0 and sets `forced_off` to 1 at that edge. This happens whatever the earlier value of `pwr_en`. The hold count never exceeds HOLD_OFF_CYC.
- R6: After a forced power-off, the key is ignored until it has been released. Continuing the same hold does not raise `pwr_en`.
- R7: `forced_off` stays 1 until a later key hold turns the domain on. `forced_off` clears at the same edge that raises `pwr_en`.
- R8: When `fw_off_req` is 1 at a clock edge, `pwr_en` is 0 after that edge. The request wins over a key-on threshold reached at the same edge. The forced power-off wins over the request.
- R9: If `pwr_en` is already 1, reaching the on-threshold leaves `pwr_en` at 1 and `forced_off` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw | input | 1 | Unsynchronised wake-up key, high while pressed |
| fw_off_req | input | 1 | Synchronous firmware power-off request |
| pwr_en | output | 1 | Enable for the switched power domain |
| forced_off | output | 1 | Set when the long hold forced the domain off |

## Verification
Each key result is due a fixed number of edges after the press. Power-on comes SYNC_STAGES + DEBOUNCE_CYC + HOLD_ON_CYC + 1 edges after the press, and forced power-off comes SYNC_STAGES + DEBOUNCE_CYC + HOLD_OFF_CYC + 1 edges after it. A firmware request takes effect at the next edge. The bench records the press cycle and queues the expected output pair for the cycle just before each due edge and for the due edge itself. A monitor compares the outputs at the falling edge of that exact cycle. An off-by-one in any stage therefore shows up as a mismatch.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
   // Bits needed to hold values 0..n inclusive, never less than one.
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_ON    = 2'd1,
      ACT_FWOFF = 2'd2,
      ACT_FORCE = 2'd3
   } pwr_act_e;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/wkp_debounce.sv
module wkp_debounce #(
   parameter int DEB_CYC = 328
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int DW = wkp_pkg::cnt_bits(DEB_CYC);

   if (DEB_CYC <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) dout <= 1'b0;
         else        dout <= din;
   end else begin : g_filter
      localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);
      logic [DW-1:0] run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run  <= '0;
            dout <= 1'b0;
         end else if (din != dout) begin
            if (run == LAST) begin
               dout <= din;
               run  <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end else begin
            run <= '0;
         end
      end
   end

   // R2
   db_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $past(din) == dout);
endmodule

// File: rtl/wkp_hold_cnt.sv
module wkp_hold_cnt #(
   parameter int ON_CYC  = 32768,
   parameter int OFF_CYC = 327680
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   output logic on_hit,
   output logic off_hit
);
   localparam int CW = wkp_pkg::cnt_bits(OFF_CYC);
   localparam logic [CW-1:0] ON_V  = CW'(ON_CYC);
   localparam logic [CW-1:0] OFF_V = CW'(OFF_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!held)      cnt <= '0;
      else if (cnt != OFF_V) cnt <= cnt + 1'b1;
   end

   assign on_hit  = held && (cnt == ON_V);
   assign off_hit = held && (cnt == OFF_V);

   // R4
   release_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !held |=> cnt == '0);
   // R5
   hold_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= OFF_V);
endmodule

// File: rtl/wkey_pwr_ctrl.sv
module wkey_pwr_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int DEBOUNCE_CYC = 328,
   parameter int HOLD_ON_CYC  = 32768,
   parameter int HOLD_OFF_CYC = 327680
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_raw,
   input  logic fw_off_req,
   output logic pwr_en,
   output logic forced_off
);
   import wkp_pkg::*;

   initial begin
      if (SYNC_STAGES < 2)            $fatal(1, "SYNC_STAGES must be at least 2");
      if (DEBOUNCE_CYC < 1)           $fatal(1, "DEBOUNCE_CYC must be at least 1");
      if (HOLD_ON_CYC < 1)            $fatal(1, "HOLD_ON_CYC must be at least 1");
      if (HOLD_OFF_CYC <= HOLD_ON_CYC) $fatal(1, "HOLD_OFF_CYC must exceed HOLD_ON_CYC");
   end

   logic key_s, key_db, on_hit, off_hit, lock;
   pwr_act_e act;

   wkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(key_raw), .dout(key_s));

   wkp_debounce #(.DEB_CYC(DEBOUNCE_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .din(key_s), .dout(key_db));

   wkp_hold_cnt #(.ON_CYC(HOLD_ON_CYC), .OFF_CYC(HOLD_OFF_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .held(key_db), .on_hit(on_hit), .off_hit(off_hit));

   // Priority: forced off, then firmware off, then key on.
   always_comb begin
      if (off_hit && !lock)     act = ACT_FORCE;
      else if (fw_off_req)      act = ACT_FWOFF;
      else if (on_hit && !lock) act = ACT_ON;
      else                      act = ACT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_en     <= 1'b0;
         forced_off <= 1'b0;
         lock       <= 1'b0;
      end else begin
         if (!key_db) lock <= 1'b0;
         case (act)
            ACT_FORCE: begin
               pwr_en     <= 1'b0;
               forced_off <= 1'b1;
               lock       <= 1'b1;
            end
            ACT_FWOFF: pwr_en <= 1'b0;
            ACT_ON: begin
               pwr_en     <= 1'b1;
               forced_off <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // R8
   fw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_off_req && !lock) |=> !pwr_en);
   // R5
   force_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(forced_off) |-> !pwr_en);
   // R7
   on_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> !forced_off);
   // R6
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && key_db) |=> !$rose(pwr_en));
endmodule

// File: tb/wkey_pwr_ctrl_test.sv
module wkey_pwr_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;
   localparam int DEB  = 4;
   localparam int ON   = 20;
   localparam int OFF  = 60;
   localparam int L_ON  = SYNC + DEB + ON + 1;
   localparam int L_OFF = SYNC + DEB + OFF + 1;

   typedef struct {
      int    cyc;
      bit    pe;
      bit    fo;
      string req;
   } exp_t;

   logic clk = 0, rst_n = 0, key_raw = 0, fw_off_req = 0;
   logic pwr_en, forced_off;
   int cyc = 0;
   int n_chk = 0, n_bad = 0;
   exp_t q[$];
   bit done = 0;

   wkey_pwr_ctrl #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYC(DEB),
                   .HOLD_ON_CYC(ON), .HOLD_OFF_CYC(OFF)) uut (
      .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .fw_off_req(fw_off_req),
      .pwr_en(pwr_en), .forced_off(forced_off));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int c, input bit pe, input bit fo, input string r);
      exp_t e;
      e.cyc = c; e.pe = pe; e.fo = fo; e.req = r;
      q.push_back(e);
   endtask

   task automatic compare(input bit pe, input bit fo, input string r);
      n_chk++;
      if (pwr_en !== pe || forced_off !== fo) begin
         n_bad++;
         $display("FAIL %s cyc=%0d pwr_en/forced_off actual=%b%b expected=%b%b",
                  r, cyc, pwr_en, forced_off, pe, fo);
      end
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // Monitor: pops expectations as their cycle comes due.
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         e = q.pop_front();
         if (e.cyc < cyc) begin
            n_chk++; n_bad++;
            $display("FAIL %s missed cyc=%0d actual=none expected=%0d", e.req, cyc, e.cyc);
         end else begin
            compare(e.pe, e.fo, e.req);
         end
      end
   end

   task automatic finish_run();
      if (q.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL queue actual=%0d pending expected=0", q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait (cyc >= 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      int p;
      @(negedge clk); @(negedge clk);
      compare(1'b0, 1'b0, "R1 in reset");
      rst_n = 1;
      expect_at(cyc + 1, 1'b0, 1'b0, "R1 after reset");

      // R2: glitch shorter than debounce
      wait_to(cyc + 5); p = cyc;
      key_raw = 1; wait_to(p + 3); key_raw = 0;
      expect_at(p + L_ON + 5, 1'b0, 1'b0, "R2 glitch ignored");
      wait_to(p + L_ON + 10);

      // R4: short hold, release, fresh press times from new press
      p = cyc; key_raw = 1;
      expect_at(p + 14, 1'b0, 1'b0, "R4 short hold");
      wait_to(p + 15); key_raw = 0;
      expect_at(p + L_ON, 1'b0, 1'b0, "R4 no on from broken hold");
      wait_to(p + 30); p = cyc; key_raw = 1;
      expect_at(p + L_ON - 1, 1'b0, 1'b0, "R3 one edge early");
      expect_at(p + L_ON, 1'b1, 1'b0, "R3 power on");
      wait_to(p + 30); key_raw = 0;
      wait_to(p + 45);

      // R9: already on, threshold again
      p = cyc; key_raw = 1;
      expect_at(p + L_ON + 3, 1'b1, 1'b0, "R9 stays on");
      wait_to(p + 40); key_raw = 0;
      wait_to(p + 55);

      // R8: firmware off
      p = cyc; fw_off_req = 1;
      expect_at(p + 1, 1'b0, 1'b0, "R8 firmware off");
      wait_to(p + 1); fw_off_req = 0;
      wait_to(p + 5);

      // R8 vs key-on same edge, then R5 / R6
      p = cyc; key_raw = 1;
      wait_to(p + L_ON - 1); fw_off_req = 1;
      expect_at(p + L_ON, 1'b0, 1'b0, "R8 beats key on");
      wait_to(p + L_ON); fw_off_req = 0;
      expect_at(p + 40, 1'b0, 1'b0, "R8 no later on");
      expect_at(p + L_OFF - 1, 1'b0, 1'b0, "R5 before force");
      expect_at(p + L_OFF, 1'b0, 1'b1, "R5 forced off flag");
      expect_at(p + L_OFF + 30, 1'b0, 1'b1, "R6 key ignored while held");
      wait_to(p + L_OFF + 31); key_raw = 0;
      expect_at(p + L_OFF + 50, 1'b0, 1'b1, "R7 flag held after release");
      wait_to(p + L_OFF + 55);

      // R7 on clears flag, then R5 forced off from on state
      p = cyc; key_raw = 1;
      expect_at(p + L_ON - 1, 1'b0, 1'b1, "R7 flag until on");
      expect_at(p + L_ON, 1'b1, 1'b0, "R7 on clears flag");
      expect_at(p + L_OFF - 1, 1'b1, 1'b0, "R5 on before force");
      expect_at(p + L_OFF, 1'b0, 1'b1, "R5 force from on");
      wait_to(p + L_OFF + 10); key_raw = 0;
      wait_to(p + L_OFF + 25);

      // R1: asynchronous reset while on
      p = cyc; key_raw = 1;
      expect_at(p + L_ON, 1'b1, 1'b0, "R3 on again");
      wait_to(p + L_ON + 2); key_raw = 0;
      wait_to(p + L_ON + 4);
      #2 rst_n = 0;
      #1 compare(1'b0, 1'b0, "R1 async reset");
      @(negedge clk); rst_n = 1;
      @(negedge clk); @(negedge clk);
      done = 1;
      finish_run();
   end
endmodule